// File: doc/BRIEF.md
# Smart Card Receive Bit Sampler

This block receives asynchronous serial characters on the data line of a smart card interface. A base-clock enable gives the timing reference, and its rate is a selectable multiple of the bit rate. A 3-bit ratio code picks one of eight oversampling ratios, including the non-power-of-two values 93, 186 and 372.

When the receiver is idle, it watches for a high-to-low transition of the line on a base-clock tick. That tick aligns a per-bit counter. Each bit is then sampled once, at the middle count of its period. The start bit is checked again at its midpoint, so a short low pulse is discarded. The receiver shifts in eight data bits, least significant first, and then a parity bit. After the parity bit it presents the byte and an even-parity error flag with a single-cycle valid strobe. It then re-arms at once for the next start edge.

Top module: `sc_rx_sampler`

## Requirements
- R1: The ratio code `ratioSel` selects the base ticks per bit N as follows: 0→32, 1→64, 2→372, 3→256, 4→93, 5→128, 6→186, 7→512.
- R2: In idle, a start is detected on a tick where the synchronised line is low and was high on the previous tick. That tick counts as count 0 of the start bit.
- R3: The per-bit counter runs from 0 to N-1, advances only on ticks, and wraps to 0 at the start of each following bit.
- R4: Each bit is sampled on the tick where the counter equals floor(N/2): 16, 32, 186, 128, 46, 64, 93 or 256 for codes 0 to 7. A low pulse lasting floor(N/2) ticks is therefore rejected, and one lasting floor(N/2)+1 ticks is accepted as a start bit.
- R5: If the line is high at the start-bit midpoint, the event is a glitch. The receiver returns to idle, no valid strobe is given, and `dataOut` keeps its value.
- R6: A character is 10 bits: a start bit, eight data bits assembled LSB first into `dataOut[0]` to `dataOut[7]`, and a parity bit.
- R7: `parityErr` is 1 when the eight data bits plus the parity bit contain an odd number of ones.
- R8: `dataValid` is high for exactly one clock after the parity-bit sample. `dataOut` and `parityErr` change only with it and hold until the next strobe.
- R9: `ratioSel` is captured only at start detection. A change during a character does not affect that character.
- R10: With `baseEn` low, the bit timing does not advance. A base tick every other clock gives correct reception of characters timed in ticks.
- R11: After reset, `dataValid`, `parityErr` and `dataOut` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| baseEn | input | 1 | Base-clock tick enable |
| ratioSel | input | 3 | Oversampling ratio code |
| rxLine | input | 1 | Serial receive line, idle high |
| dataOut | output | 8 | Last received data byte |
| parityErr | output | 1 | Even-parity error of the last character |
| dataValid | output | 1 | One-cycle character strobe |

## Verification
The assertions watch the timing skeleton on every cycle:
- the counter stays below the latched ratio and freezes without a tick;
- the latched ratio is stable during a character;
- the bit index stays in range;
- the output strobe lasts a single cycle, and the data changes only with it.

Only the bench scenarios can show the sampling behaviour itself. These cover the midpoint position at the exact rejection boundary, LSB-first assembly and parity across all eight ratios, glitch rejection, ratio changes in mid-character, and a divided tick rate.

// File: rtl/sc_rx_pkg.sv
package sc_rx_pkg;

  parameter int CNT_W = 10;

  // strobes from control to datapath
  typedef struct packed {
    logic shift;
    logic done;
    logic bitVal;
  } rxStrobe_t;

  function automatic logic [CNT_W-1:0] ratioOf(input logic [2:0] sel);
    logic [CNT_W-1:0] n;
    case (sel)
      3'd0: n = CNT_W'(32);
      3'd1: n = CNT_W'(64);
      3'd2: n = CNT_W'(372);
      3'd3: n = CNT_W'(256);
      3'd4: n = CNT_W'(93);
      3'd5: n = CNT_W'(128);
      3'd6: n = CNT_W'(186);
      default: n = CNT_W'(512);
    endcase
    return n;
  endfunction

endpackage

// File: rtl/sc_rx_ctrl.sv
module sc_rx_ctrl
  import sc_rx_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int FRAME_BITS  = 10
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       baseEn,
  input  logic [2:0] ratioSel,
  input  logic       rxLine,
  output rxStrobe_t  strobe
);

  localparam int IDX_W = $clog2(FRAME_BITS);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BITS - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_START, ST_BITS} rxState_t;

  // line synchroniser
  logic [SYNC_STAGES-1:0] syncQ;
  logic lineS;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= '1;
    else       syncQ <= {syncQ[SYNC_STAGES-2:0], rxLine};
  end
  assign lineS = syncQ[SYNC_STAGES-1];

  rxState_t         state;
  logic             prevLine;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] ratioQ;
  logic [IDX_W-1:0] bitIdx;
  logic [CNT_W-1:0] lastCnt;
  logic [CNT_W-1:0] midCnt;
  logic             busy;
  logic             atMid;
  logic             atEnd;

  assign lastCnt = ratioQ - CNT_W'(1);
  assign midCnt  = ratioQ >> 1;
  assign busy    = (state != ST_IDLE);
  assign atMid   = baseEn && busy && (cnt == midCnt);
  assign atEnd   = baseEn && busy && (cnt == lastCnt);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      prevLine <= 1'b1;
      cnt      <= '0;
      ratioQ   <= ratioOf(3'd0);
      bitIdx   <= '0;
    end else if (baseEn) begin
      prevLine <= lineS;
      if (state == ST_IDLE) begin
        if (prevLine && !lineS) begin
          state  <= ST_START;
          cnt    <= CNT_W'(1);
          bitIdx <= '0;
          ratioQ <= ratioOf(ratioSel);
        end
      end else begin
        if (atEnd) begin
          cnt    <= '0;
          bitIdx <= bitIdx + IDX_W'(1);
          if (state == ST_START) state <= ST_BITS;
        end else begin
          cnt <= cnt + CNT_W'(1);
        end
        if (atMid) begin
          if (state == ST_START && lineS)                state <= ST_IDLE;
          else if (state == ST_BITS && bitIdx == LAST_IDX) state <= ST_IDLE;
        end
      end
    end
  end

  always_comb begin
    strobe.bitVal = lineS;
    strobe.shift  = atMid && (state == ST_BITS);
    strobe.done   = atMid && (state == ST_BITS) && (bitIdx == LAST_IDX);
  end

  assert_cnt_below_ratio_R3 : assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (cnt < ratioQ));

  assert_hold_without_tick_R10 : assert property (@(posedge clk) disable iff (!rstN)
    !baseEn |=> $stable(cnt) && $stable(state));

  assert_ratio_held_R9 : assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable(ratioQ));

  assert_bit_index_R6 : assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (bitIdx <= LAST_IDX));

  assert_start_on_low_R2 : assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_START && $past(state) == ST_IDLE) |-> $past(!lineS));

endmodule

// File: rtl/sc_rx_dpath.sv
module sc_rx_dpath
  import sc_rx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  rxStrobe_t         strobe,
  output logic [DATA_W-1:0] dataOut,
  output logic              parityErr,
  output logic              dataValid
);

  localparam int SH_W = DATA_W + 1;

  logic [SH_W-1:0] shReg;
  logic [SH_W-1:0] nextReg;

  // LSB first: new bit enters at the top and walks down
  assign nextReg = {strobe.bitVal, shReg[SH_W-1:1]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg     <= '0;
      dataOut   <= '0;
      parityErr <= 1'b0;
      dataValid <= 1'b0;
    end else begin
      dataValid <= strobe.done;
      if (strobe.shift) shReg <= nextReg;
      if (strobe.done) begin
        dataOut   <= nextReg[DATA_W-1:0];
        parityErr <= ^nextReg;
      end
    end
  end

  assert_valid_single_R8 : assert property (@(posedge clk) disable iff (!rstN)
    dataValid |=> !dataValid);

  assert_out_changes_with_valid_R8 : assert property (@(posedge clk) disable iff (!rstN)
    !$stable(dataOut) |-> dataValid);

endmodule

// File: rtl/sc_rx_sampler.sv
module sc_rx_sampler
  import sc_rx_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DATA_W      = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              baseEn,
  input  logic [2:0]        ratioSel,
  input  logic              rxLine,
  output logic [DATA_W-1:0] dataOut,
  output logic              parityErr,
  output logic              dataValid
);

  localparam int FRAME_BITS = DATA_W + 2;

  rxStrobe_t strobe;

  sc_rx_ctrl #(
    .SYNC_STAGES(SYNC_STAGES),
    .FRAME_BITS (FRAME_BITS)
  ) i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .baseEn  (baseEn),
    .ratioSel(ratioSel),
    .rxLine  (rxLine),
    .strobe  (strobe)
  );

  sc_rx_dpath #(
    .DATA_W(DATA_W)
  ) i_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .dataOut  (dataOut),
    .parityErr(parityErr),
    .dataValid(dataValid)
  );

endmodule

// File: tb/test_sc_rx_sampler.sv
module test_sc_rx_sampler;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       baseEn = 1'b1;
  logic [2:0] ratioSel = 3'd0;
  logic       rxLine = 1'b1;
  logic [7:0] dataOut;
  logic       parityErr;
  logic       dataValid;

  int tests = 0;
  int fails = 0;
  int tickDiv = 1;
  int phase = 0;
  bit finished = 1'b0;
  logic [8:0] expQ[$];   // {parityErr, data}
  logic prevValid = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  sc_rx_sampler i_sc_rx_sampler (
    .clk(clk), .rstN(rstN), .baseEn(baseEn), .ratioSel(ratioSel),
    .rxLine(rxLine), .dataOut(dataOut), .parityErr(parityErr),
    .dataValid(dataValid)
  );

  function automatic int ratioN(input int code);
    case (code)
      0: return 32;   1: return 64;   2: return 372;  3: return 256;
      4: return 93;   5: return 128;  6: return 186;  default: return 512;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // tick generator
  always @(negedge clk) begin
    if (phase + 1 >= tickDiv) phase = 0;
    else phase = phase + 1;
    baseEn = (phase == 0);
  end

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rstN) begin
      if (prevValid) check(!dataValid, "R8 single-cycle strobe", dataValid, 0);
      if (dataValid) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R5 unexpected character", {parityErr, dataOut}, 0);
        end else begin
          logic [8:0] e;
          e = expQ.pop_front();
          check(dataOut == e[7:0], "R1 R4 R6 data", dataOut, e[7:0]);
          check(parityErr == e[8], "R7 parity flag", parityErr, e[8]);
        end
      end
      prevValid = dataValid;
    end
  end

  task automatic sendFrame(input logic [7:0] d, input logic par, input int code,
                           input int altCode);
    int n;
    n = ratioN(code);
    ratioSel = 3'(code);
    expQ.push_back({^{d, par}, d});
    for (int i = 0; i < 10; i++) begin
      rxLine = (i == 0) ? 1'b0 : (i <= 8) ? d[i-1] : par;
      repeat (n * tickDiv) @(negedge clk);
      if (i == 0 && altCode >= 0) ratioSel = 3'(altCode);
    end
    rxLine = 1'b1;
    repeat (40) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    check(dataValid == 1'b0, "R11 valid at reset", dataValid, 0);
    check(parityErr == 1'b0, "R11 parity at reset", parityErr, 0);
    check(dataOut == 8'h00, "R11 data at reset", dataOut, 0);
    rstN = 1'b1;
    repeat (10) @(negedge clk);

    // R1 R4 R6 R7: every ratio, distinct patterns and parity
    sendFrame(8'hA5, 1'b0, 0, -1);
    sendFrame(8'h01, 1'b0, 1, -1);
    sendFrame(8'h3C, 1'b1, 2, -1);
    sendFrame(8'h80, 1'b1, 3, -1);
    sendFrame(8'hF0, 1'b1, 4, -1);
    sendFrame(8'h00, 1'b0, 5, -1);
    sendFrame(8'h7E, 1'b1, 6, -1);
    sendFrame(8'hC3, 1'b0, 7, -1);

    // R9: ratio code changes mid-character (372 -> 32)
    sendFrame(8'h5A, 1'b1, 2, 0);

    // R5 / R4 boundary: low pulse of floor(93/2)=46 ticks is a glitch
    ratioSel = 3'd4;
    rxLine = 1'b0;
    repeat (46) @(negedge clk);
    rxLine = 1'b1;
    repeat (1200) @(negedge clk);
    check(expQ.size() == 0, "R5 glitch gives no character", expQ.size(), 0);
    check(dataOut == 8'h5A, "R5 data held after glitch", dataOut, 8'h5A);

    // R4 boundary: 47 ticks low accepted, rest high -> FF with parity bit 1
    expQ.push_back({1'b1, 8'hFF});
    rxLine = 1'b0;
    repeat (47) @(negedge clk);
    rxLine = 1'b1;
    repeat (1200) @(negedge clk);

    // R10: tick every other clock
    tickDiv = 2;
    repeat (10) @(negedge clk);
    sendFrame(8'h96, 1'b1, 0, -1);
    sendFrame(8'h4B, 1'b1, 4, -1);
    tickDiv = 1;

    // R8: re-arm right after a character with parity bit low
    sendFrame(8'h12, 1'b0, 1, -1);
    sendFrame(8'h34, 1'b1, 1, -1);

    repeat (50) @(negedge clk);
    check(expQ.size() == 0, "R8 all characters delivered", expQ.size(), 0);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule